// File: doc/BRIEF.md
# Configurable Dual Line Decoder and Demultiplexer

This combinational block holds two 2-to-4 decoding sections. They share one pair of select lines. Each section has its own enable strobe and its own data line, and each drives four active-low outputs. The two sections respond to opposite levels on their data lines. The "upper" section passes its addressed output low only when its data line is high. The "lower" section does so only when its data line is low. Used separately, each section is a 2-to-4 decoder, or a 1-to-4 demultiplexer that steers its data line.

A static configuration input switches the block into wide mode. In wide mode both sections take one shared code line and one shared strobe, and the per-section pins are ignored. The shared code line then works as a third, most significant select bit. Because of the opposite polarities, a code of 0 reaches the lower section and a code of 1 reaches the upper section. The block then acts as one 3-to-8 decoder.

Two function outputs NAND chosen pairs of the active-low outputs. In wide mode they form two sum-of-minterm functions of the three select bits.

Top module: `dmx_dual_decoder`

## Requirements
- R1: All eight outputs of `y_n` are active-low. Bit i of `y_n` is low only when it is addressed and enabled; otherwise it is 1. `y_n[3:0]` belongs to the lower section (lane i = bit i) and `y_n[7:4]` to the upper section (lane i = bit 4+i).
- R2: In dual mode (`cfg_wide`=0), a high `up_stb_n` forces `y_n[7:4]` to 4'b1111 and a high `lo_stb_n` forces `y_n[3:0]` to 4'b1111, whatever the other inputs are.
- R3: In dual mode, with `up_stb_n`=0 and `up_data`=1, bit 4+`sel` of `y_n` goes low. With `up_data`=0, `y_n[7:4]` stays 4'b1111.
- R4: In dual mode, with `lo_stb_n`=0 and `lo_data`=0, bit `sel` of `y_n` goes low. With `lo_data`=1, `y_n[3:0]` stays 4'b1111.
- R5: `sel[1]` is the more significant select bit and `sel[0]` the less significant one. The value of `sel` (0 to 3) is the lane index within a section, and both sections share it.
- R6: In wide mode (`cfg_wide`=1) with `wide_g_n`=0, exactly bit {`wide_c`,`sel`} of `y_n` is low. Codes 0 to 3 fall on the lower section and codes 4 to 7 on the upper section.
- R7: In wide mode, `wide_g_n`=1 forces all of `y_n` to 8'hFF.
- R8: In wide mode, `up_data`, `lo_data`, `up_stb_n` and `lo_stb_n` have no effect on any output.
- R9: `fn1` is the NAND of `y_n[7]` and `y_n[0]`. `fn2` is the NAND of `y_n[6]` and `y_n[4]`. In wide mode with the strobe low, `fn1` is therefore high for code 7 or 0, and `fn2` is high for code 6 or 4.
- R10: At most one output of each section is low. In wide mode, at most one of all eight outputs is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_wide | input | 1 | 0 = two independent sections, 1 = single 3-to-8 decoder |
| sel | input | 2 | Shared select code {B, A} |
| up_data | input | 1 | Upper section data line, active-high (dual mode) |
| up_stb_n | input | 1 | Upper section strobe, active-low (dual mode) |
| lo_data | input | 1 | Lower section data line, active-low (dual mode) |
| lo_stb_n | input | 1 | Lower section strobe, active-low (dual mode) |
| wide_c | input | 1 | Most significant code bit in wide mode |
| wide_g_n | input | 1 | Shared strobe in wide mode, active-low |
| y_n | output | 8 | Active-low decoded outputs, bit i = code i in wide mode |
| fn1 | output | 1 | NAND of y_n[7] and y_n[0] |
| fn2 | output | 1 | NAND of y_n[6] and y_n[4] |

## Verification
The hardest case to reach from the ports is proving that the per-section pins have no effect in wide mode. A sweep that holds the dual-mode pins at rest would never disturb them. The bench therefore walks every combination of all eight inputs in wide mode, 256 vectors, so each wide code and strobe value is seen under all sixteen settings of the unused pins. Dual mode is covered by all 64 combinations of its six live inputs. Each vector is scored against a truth-table model kept in the bench.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int SEL_W = 2;
    localparam int LANES = 1 << SEL_W;
    localparam int TOTAL = 2 * LANES;
    localparam int CODE_W = SEL_W + 1;

    // minterm picks for the two function outputs
    localparam int F1_MA = 7;
    localparam int F1_MB = 0;
    localparam int F2_MA = 6;
    localparam int F2_MB = 4;

    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_WIDE = 1'b1
    } mode_e;

    typedef struct packed {
        logic data;
        logic stb_n;
    } sec_ctl_t;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [LANES-1:0] lanes_t;

    function automatic logic nand2(input logic a, input logic b);
        return ~(a & b);
    endfunction
endpackage

// File: rtl/dmx_section.sv
module dmx_section
    import dmx_pkg::*;
#(
    parameter bit DATA_ACT_HIGH = 1'b1
) (
    input  sec_ctl_t ctl,
    input  sel_t     sel,
    output lanes_t   y_n
);
    logic en;

    always_comb begin
        en = ~ctl.stb_n & (ctl.data == DATA_ACT_HIGH);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign y_n[i] = ~(en & (sel == sel_t'(i)));
    end

    always_comb begin
        // strobe high leaves every lane high
        assert_stb_block_R2: assert (!ctl.stb_n || y_n == '1)
            else $error("section strobe did not block outputs");
        // data line at its inactive level leaves every lane high (R4 for lower section)
        assert_data_gate_R3: assert (ctl.data == DATA_ACT_HIGH || y_n == '1)
            else $error("section data gate failed");
        assert_one_low_R10: assert ($countones(~y_n) <= 1)
            else $error("more than one lane low in section");
    end
endmodule

// File: rtl/dmx_route.sv
module dmx_route
    import dmx_pkg::*;
(
    input  mode_e    mode,
    input  sec_ctl_t up_pins,
    input  sec_ctl_t lo_pins,
    input  logic     wide_c,
    input  logic     wide_g_n,
    output sec_ctl_t up_ctl,
    output sec_ctl_t lo_ctl
);
    sec_ctl_t tied;

    always_comb begin
        tied.data  = wide_c;
        tied.stb_n = wide_g_n;
        if (mode == MODE_WIDE) begin
            up_ctl = tied;
            lo_ctl = tied;
        end else begin
            up_ctl = up_pins;
            lo_ctl = lo_pins;
        end
    end

    always_comb begin
        assert_tied_R8: assert (mode != MODE_WIDE || up_ctl == lo_ctl)
            else $error("wide mode sections not tied");
    end
endmodule

// File: rtl/dmx_fngen.sv
module dmx_fngen
    import dmx_pkg::*;
(
    input  logic [TOTAL-1:0] y_n,
    output logic             fn1,
    output logic             fn2
);
    always_comb begin
        fn1 = nand2(y_n[F1_MA], y_n[F1_MB]);
        fn2 = nand2(y_n[F2_MA], y_n[F2_MB]);
    end
endmodule

// File: rtl/dmx_dual_decoder.sv
module dmx_dual_decoder
    import dmx_pkg::*;
(
    input  logic       cfg_wide,
    input  logic [1:0] sel,
    input  logic       up_data,
    input  logic       up_stb_n,
    input  logic       lo_data,
    input  logic       lo_stb_n,
    input  logic       wide_c,
    input  logic       wide_g_n,
    output logic [7:0] y_n,
    output logic       fn1,
    output logic       fn2
);
    mode_e    mode;
    sec_ctl_t up_pins, lo_pins, up_ctl, lo_ctl;
    lanes_t   up_y_n, lo_y_n;
    logic [CODE_W-1:0] code;

    always_comb begin
        mode           = mode_e'(cfg_wide);
        up_pins.data   = up_data;
        up_pins.stb_n  = up_stb_n;
        lo_pins.data   = lo_data;
        lo_pins.stb_n  = lo_stb_n;
        code           = {wide_c, sel};
    end

    dmx_route u_route (
        .mode     (mode),
        .up_pins  (up_pins),
        .lo_pins  (lo_pins),
        .wide_c   (wide_c),
        .wide_g_n (wide_g_n),
        .up_ctl   (up_ctl),
        .lo_ctl   (lo_ctl)
    );

    dmx_section #(.DATA_ACT_HIGH(1'b1)) u_up (
        .ctl (up_ctl),
        .sel (sel),
        .y_n (up_y_n)
    );

    dmx_section #(.DATA_ACT_HIGH(1'b0)) u_lo (
        .ctl (lo_ctl),
        .sel (sel),
        .y_n (lo_y_n)
    );

    assign y_n = {up_y_n, lo_y_n};

    dmx_fngen u_fn (
        .y_n (y_n),
        .fn1 (fn1),
        .fn2 (fn2)
    );

    always_comb begin
        assert_wide_single_R10: assert (!cfg_wide || $countones(~y_n) <= 1)
            else $error("wide mode has several outputs low");
        assert_wide_block_R7: assert (!(cfg_wide && wide_g_n) || y_n == 8'hFF)
            else $error("wide strobe did not block");
        assert_wide_pick_R6: assert (!(cfg_wide && !wide_g_n) || !y_n[code])
            else $error("addressed wide output not low");
        assert_fn1_R9: assert (!(cfg_wide && !wide_g_n) || fn1 == (code == 3'd7 || code == 3'd0))
            else $error("fn1 wrong minterms");
    end
endmodule

// File: tb/tb_dmx_dual_decoder.sv
module tb_dmx_dual_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic [7:0] y;
        logic       f1;
        logic       f2;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wide = 1'b0, up_data = 1'b0, up_stb_n = 1'b1;
    logic lo_data = 1'b1, lo_stb_n = 1'b1, wide_c = 1'b0, wide_g_n = 1'b1;
    logic [1:0] sel = 2'd0;
    logic [7:0] y_n;
    logic fn1, fn2;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit drv_done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmx_dual_decoder dut (
        .cfg_wide(cfg_wide), .sel(sel), .up_data(up_data), .up_stb_n(up_stb_n),
        .lo_data(lo_data), .lo_stb_n(lo_stb_n), .wide_c(wide_c), .wide_g_n(wide_g_n),
        .y_n(y_n), .fn1(fn1), .fn2(fn2)
    );

    // truth-table model
    function automatic logic [7:0] model_y(logic w, logic [1:0] s, logic ud, logic us,
                                           logic ld, logic ls, logic c, logic g);
        logic [7:0] r;
        r = 8'hFF;
        if (w) begin
            if (!g) r[{c, s}] = 1'b0;
        end else begin
            if (!us && ud)  r[4 + s] = 1'b0;
            if (!ls && !ld) r[s]     = 1'b0;
        end
        return r;
    endfunction

    task automatic apply(logic w, logic [1:0] s, logic ud, logic us,
                         logic ld, logic ls, logic c, logic g, string tag);
        exp_t e;
        @(posedge clk);
        #1;
        cfg_wide = w; sel = s; up_data = ud; up_stb_n = us;
        lo_data = ld; lo_stb_n = ls; wide_c = c; wide_g_n = g;
        e.y  = model_y(w, s, ud, us, ld, ls, c, g);
        if (w && !g) begin
            e.f1 = ({c, s} == 3'd7) || ({c, s} == 3'd0);
            e.f2 = ({c, s} == 3'd6) || ({c, s} == 3'd4);
        end else begin
            e.f1 = ~(e.y[7] & e.y[0]);
            e.f2 = ~(e.y[6] & e.y[4]);
        end
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (y_n !== e.y) begin
                bad++;
                $display("FAIL %s y_n got=%b exp=%b", e.tag, y_n, e.y);
            end
            total++;
            if (fn1 !== e.f1 || fn2 !== e.f2) begin
                bad++;
                $display("FAIL R9 fn got=%b%b exp=%b%b", fn1, fn2, e.f1, e.f2);
            end
            total++;
            if ($countones(~y_n[3:0]) > 1 || $countones(~y_n[7:4]) > 1 ||
                (cfg_wide && $countones(~y_n) > 1)) begin
                bad++;
                $display("FAIL R10 y_n got=%b exp=at most one low", y_n);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog got=%0d cycles exp<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset state: all strobes inactive -> all outputs high (R1)
        #2;
        total++;
        if (y_n !== 8'hFF) begin
            bad++;
            $display("FAIL R1 idle y_n got=%b exp=%b", y_n, 8'hFF);
        end
        // dual mode exhaustive: R1 R2 R3 R4 R5
        for (int v = 0; v < 64; v++) begin
            logic [5:0] b;
            b = 6'(v);
            apply(1'b0, b[1:0], b[2], b[3], b[4], b[5], 1'b0, 1'b1,
                  "R1 R2 R3 R4 R5 dual");
        end
        // wide mode exhaustive incl. ignored pins: R6 R7 R8
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            apply(1'b1, b[1:0], b[4], b[5], b[6], b[7], b[2], b[3],
                  (b[3] ? "R7 R8 wide blocked" : "R6 R8 wide"));
        end
        drv_done = 1'b1;
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule